// File: doc/BRIEF.md
# Age-Ordered Speculative Reservation Station

This block is an eight-slot holding queue for decoded micro-operations waiting in front of a single execution unit in an out-of-order core. Each accepted operation carries two source tags with ready flags, a destination tag, an opaque payload and an age stamp. The queue tracks operand readiness by watching a committed result bus and an early wakeup bus. An early wakeup signals that a value will exist by the time execution starts.

Each cycle the queue offers at most one operation to the unit. An operation is eligible only when both of its operands are ready or promised. Among the eligible operations, the one with the oldest age stamp is chosen. An operation sent out on a promise alone stays in its slot for one more cycle. If a cancel for the promised tag arrives in that cycle, the operation drops back to waiting. If no cancel arrives, its slot is released. A flush with an age boundary removes every operation younger than the boundary within a single cycle.

Top module: `age_rs`

## Requirements
- R1: After reset the queue is empty: `full` is low and `iss_valid` is low.
- R2: One operation is accepted per cycle when `ins_valid` is high and a slot is free. `full` is high exactly when all 8 slots hold operations. An insertion offered while `full` is high is ignored.
- R3: An operation can be dispatched only when each of its sources is either committed-ready or early-woken. A newly inserted operation is never dispatched in its own insertion cycle. With no eligible operation, `iss_valid` is low.
- R4: Among eligible operations, the one with the oldest age is dispatched. Ages are `AGE_W`-bit stamps compared modulo 2^AGE_W: a is older than b when bit AGE_W-1 of (a - b) is set.
- R5: A result broadcast (`wb_valid`, `wb_tag`) marks matching sources committed-ready from the next cycle on. An operation inserted in the same cycle as a matching broadcast captures it. A broadcast with a tag that matches no source has no effect.
- R6: An early wakeup (`ew_valid`, `ew_tag`) makes matching sources eligible from the next cycle on. An operation inserted in the same cycle as the wakeup captures it.
- R7: A cancel (`cx_valid`, `cx_tag`) in the cycle after a speculative dispatch returns the operation to waiting. The operation is dispatched again once the source is broadcast.
- R8: A dispatch whose sources are all committed-ready frees the slot at once. A speculative dispatch with no cancel in the following cycle frees the slot after that cycle. A freed operation is never dispatched again.
- R9: A flush (`fl_valid`, `fl_age`) removes, in one cycle, every resident operation strictly younger than `fl_age`, together with any operation being inserted in that cycle that is younger than `fl_age`. Operations at or older than the boundary stay.
- R10: Inserting into the last free slot in the same cycle as a dispatch is allowed, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Offer an operation for insertion |
| ins_op | input | OP_W | Payload of the offered operation |
| ins_dst | input | TAG_W | Destination tag |
| ins_src0 | input | TAG_W | First source tag |
| ins_rdy0 | input | 1 | First source already committed |
| ins_src1 | input | TAG_W | Second source tag |
| ins_rdy1 | input | 1 | Second source already committed |
| ins_age | input | AGE_W | Age stamp of the offered operation |
| full | output | 1 | All slots occupied; insertion refused |
| wb_valid | input | 1 | Committed result broadcast valid |
| wb_tag | input | TAG_W | Broadcast result tag |
| ew_valid | input | 1 | Early wakeup valid |
| ew_tag | input | TAG_W | Early wakeup tag |
| cx_valid | input | 1 | Cancel of an early wakeup |
| cx_tag | input | TAG_W | Cancelled tag |
| fl_valid | input | 1 | Flush request |
| fl_age | input | AGE_W | Flush boundary age |
| iss_valid | output | 1 | Operation offered to the unit this cycle |
| iss_op | output | OP_W | Payload of the dispatched operation |
| iss_dst | output | TAG_W | Destination tag of the dispatched operation |

## Verification
The assertions and the selection logic assume the following about the inputs. Resident operations carry distinct age stamps that span less than half the age range. A cancel names only a tag that was early-woken earlier, and it never comes in the same cycle as a broadcast of that tag. The stimulus meets these conditions by giving each scenario its own small, contiguous block of ages, by wrapping those blocks across the top of the stamp range, and by using a separate tag for each waiting condition. The sweeps permute insertion order against age, so the dispatch order follows from modular arithmetic alone.

// File: rtl/age_rs.sv
`timescale 1ns/1ps
module age_rs #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  parameter int OP_W  = 8,
  parameter int AGE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [OP_W-1:0]  ins_op,
  input  logic [TAG_W-1:0] ins_dst,
  input  logic [TAG_W-1:0] ins_src0,
  input  logic             ins_rdy0,
  input  logic [TAG_W-1:0] ins_src1,
  input  logic             ins_rdy1,
  input  logic [AGE_W-1:0] ins_age,
  output logic             full,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic             ew_valid,
  input  logic [TAG_W-1:0] ew_tag,
  input  logic             cx_valid,
  input  logic [TAG_W-1:0] cx_tag,
  input  logic             fl_valid,
  input  logic [AGE_W-1:0] fl_age,
  output logic             iss_valid,
  output logic [OP_W-1:0]  iss_op,
  output logic [TAG_W-1:0] iss_dst
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld, held, r0, r1, s0, s1;
  logic [OP_W-1:0]  op   [DEPTH];
  logic [TAG_W-1:0] dst  [DEPTH];
  logic [TAG_W-1:0] src0 [DEPTH];
  logic [TAG_W-1:0] src1 [DEPTH];
  logic [AGE_W-1:0] age  [DEPTH];

  logic [DEPTH-1:0] elig, win, cxh, kill;
  logic [IW-1:0]    sel, fidx;
  logic             ins_acc, ins_keep;

  function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return d[AGE_W-1];
  endfunction

  assign full      = &vld;
  assign ins_acc   = ins_valid && !full;
  assign ins_keep  = !(fl_valid && older(fl_age, ins_age));
  assign iss_valid = |win;
  assign iss_op    = op[sel];
  assign iss_dst   = dst[sel];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = vld[i] && !held[i] && (r0[i] || s0[i]) && (r1[i] || s1[i]);
      cxh[i]  = cx_valid && ((s0[i] && !r0[i] && src0[i] == cx_tag) ||
                             (s1[i] && !r1[i] && src1[i] == cx_tag));
      kill[i] = fl_valid && older(fl_age, age[i]);
    end
  end

  always_comb begin
    win = '0;
    for (int i = 0; i < DEPTH; i++) begin
      win[i] = elig[i];
      for (int j = 0; j < DEPTH; j++)
        if (j != i && elig[j] && older(age[j], age[i])) win[i] = 1'b0;
    end
  end

  always_comb begin
    sel  = '0;
    fidx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (win[i]) sel = IW'(i);
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) fidx = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      held <= '0;
      r0   <= '0;
      r1   <= '0;
      s0   <= '0;
      s1   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wb_valid && src0[i] == wb_tag) r0[i] <= 1'b1;
        if (wb_valid && src1[i] == wb_tag) r1[i] <= 1'b1;
        if (ew_valid && src0[i] == ew_tag) s0[i] <= 1'b1;
        if (ew_valid && src1[i] == ew_tag) s1[i] <= 1'b1;
        if (cx_valid && src0[i] == cx_tag) s0[i] <= 1'b0;
        if (cx_valid && src1[i] == cx_tag) s1[i] <= 1'b0;

        if (held[i]) begin
          held[i] <= 1'b0;
          if (!cxh[i]) vld[i] <= 1'b0;
        end else if (win[i]) begin
          if (r0[i] && r1[i]) vld[i] <= 1'b0;
          else if (!cxh[i])   held[i] <= 1'b1;
        end

        if (kill[i]) begin
          vld[i]  <= 1'b0;
          held[i] <= 1'b0;
        end

        if (ins_acc && ins_keep && fidx == IW'(i)) begin
          vld[i]  <= 1'b1;
          held[i] <= 1'b0;
          op[i]   <= ins_op;
          dst[i]  <= ins_dst;
          src0[i] <= ins_src0;
          src1[i] <= ins_src1;
          age[i]  <= ins_age;
          r0[i]   <= ins_rdy0 || (wb_valid && ins_src0 == wb_tag);
          r1[i]   <= ins_rdy1 || (wb_valid && ins_src1 == wb_tag);
          s0[i]   <= ew_valid && ins_src0 == ew_tag && !(cx_valid && ins_src0 == cx_tag);
          s1[i]   <= ew_valid && ins_src1 == ew_tag && !(cx_valid && ins_src1 == cx_tag);
        end
      end
    end
  end

  // R1
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|vld) |-> !iss_valid);

  // R2
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && ins_valid) |=> ($countones(vld) <= $countones($past(vld))));

  // R8
  nonspec_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && r0[sel] && r1[sel]) |=> !vld[$past(sel)]);

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      // R8
      window_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held[g] |=> !held[g]);
      // R7
      replay_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held[g] && cxh[g] && !fl_valid) |=> (vld[g] && !held[g]));
      // R9
      flush_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |=> !(vld[g] && older($past(fl_age), age[g])));
    end
  endgenerate
endmodule

// File: tb/age_rs_bench.sv
`timescale 1ns/1ps
module age_rs_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ins_valid, ins_rdy0, ins_rdy1, wb_valid, ew_valid, cx_valid, fl_valid;
  logic [7:0] ins_op;
  logic [5:0] ins_dst, ins_src0, ins_src1, wb_tag, ew_tag, cx_tag;
  logic [4:0] ins_age, fl_age;
  logic       full, iss_valid;
  logic [7:0] iss_op;
  logic [5:0] iss_dst;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  age_rs u_age_rs (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op), .ins_dst(ins_dst),
    .ins_src0(ins_src0), .ins_rdy0(ins_rdy0), .ins_src1(ins_src1), .ins_rdy1(ins_rdy1),
    .ins_age(ins_age), .full(full), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .ew_valid(ew_valid), .ew_tag(ew_tag), .cx_valid(cx_valid), .cx_tag(cx_tag),
    .fl_valid(fl_valid), .fl_age(fl_age), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dst(iss_dst));

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic idle();
    ins_valid = 0; wb_valid = 0; ew_valid = 0; cx_valid = 0; fl_valid = 0;
  endtask

  task automatic nxt();
    @(posedge clk); #1; idle();
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  task automatic ins(input int o, input int a, input int t0, input bit q0, input int t1, input bit q1);
    ins_valid = 1; ins_op = 8'(o); ins_dst = 6'(o); ins_age = 5'(a);
    ins_src0 = 6'(t0); ins_rdy0 = q0; ins_src1 = 6'(t1); ins_rdy1 = q1;
  endtask

  task automatic wb(input int t);
    wb_valid = 1; wb_tag = 6'(t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bases [4] = '{0, 12, 28, 29};
    idle();
    ins_op = 0; ins_dst = 0; ins_src0 = 0; ins_src1 = 0; ins_rdy0 = 0; ins_rdy1 = 0;
    ins_age = 0; wb_tag = 0; ew_tag = 0; cx_tag = 0; fl_age = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    smp();
    chk("R1 full", full, 0);
    chk("R1 iss_valid", iss_valid, 0);
    nxt();

    // R2 R4 sweep: age permutation (3i mod 8) over wrapping bases
    foreach (bases[b]) begin
      for (int i = 0; i < 8; i++) begin
        ins(i, (bases[b] + (i * 3) % 8) % 32, 1, 0, 2, 1);
        smp(); chk("R3 waiting", iss_valid, 0);
        nxt();
      end
      smp(); chk("R2 full", full, 1);
      ins(15, (bases[b] + 8) % 32, 2, 1, 2, 1);
      nxt();
      wb(1);
      smp(); chk("R5 not yet", iss_valid, 0);
      nxt();
      for (int k = 0; k < 8; k++) begin
        smp();
        chk("R4 valid", iss_valid, 1);
        chk("R4 order", iss_op, (3 * k) % 8);
        nxt();
      end
      smp();
      chk("R2 ninth ignored", iss_valid, 0);
      chk("R2 empty", full, 0);
      nxt();
    end

    // R5 capture on insert
    ins(42, 0, 5, 0, 2, 1); wb(5);
    smp(); chk("R3 own cycle", iss_valid, 0);
    nxt();
    smp(); chk("R5 capture", iss_valid, 1); chk("R5 op", iss_op, 42); chk("R5 dst", iss_dst, 42);
    nxt();
    smp(); chk("R8 freed", iss_valid, 0);
    nxt();

    // R5 mismatched broadcast, then matching
    ins(43, 1, 2, 1, 7, 0);
    nxt();
    smp(); chk("R3 one source", iss_valid, 0); wb(8);
    nxt();
    smp(); chk("R5 mismatch", iss_valid, 0); wb(7);
    nxt();
    smp(); chk("R5 match", iss_valid, 1); chk("R5 op", iss_op, 43);
    nxt();
    smp(); chk("R8 freed", iss_valid, 0);
    nxt();

    // R6 R8 speculative, wakeup captured on insert, no cancel
    ins(41, 2, 9, 0, 2, 1); ew_valid = 1; ew_tag = 9;
    smp(); chk("R3 own cycle", iss_valid, 0);
    nxt();
    smp(); chk("R6 spec dispatch", iss_valid, 1); chk("R6 op", iss_op, 41);
    nxt();
    smp(); chk("R8 window", iss_valid, 0);
    nxt();
    smp(); chk("R8 gone", iss_valid, 0); wb(9);
    nxt();
    smp(); chk("R8 no redispatch", iss_valid, 0); chk("R8 full", full, 0);
    nxt();

    // R7 cancel and replay
    ins(40, 3, 10, 0, 2, 1);
    nxt();
    smp(); chk("R6 before wakeup", iss_valid, 0); ew_valid = 1; ew_tag = 10;
    nxt();
    smp(); chk("R6 spec dispatch", iss_valid, 1); chk("R6 op", iss_op, 40);
    nxt();
    cx_valid = 1; cx_tag = 10;
    smp(); chk("R8 window", iss_valid, 0);
    nxt();
    smp(); chk("R7 waiting", iss_valid, 0);
    nxt();
    smp(); chk("R7 waiting", iss_valid, 0); wb(10);
    nxt();
    smp(); chk("R7 redispatch", iss_valid, 1); chk("R7 op", iss_op, 40);
    nxt();
    smp(); chk("R8 freed", iss_valid, 0);
    nxt();

    // R9 flush with wrap
    for (int b = 0; b < 2; b++) begin
      int base = (b == 0) ? 4 : 30;
      for (int k = 0; k < 4; k++) begin
        ins(50 + k, (base + k) % 32, 11, 0, 2, 1);
        nxt();
      end
      fl_valid = 1; fl_age = 5'((base + 1) % 32);
      ins(54, (base + 4) % 32, 2, 1, 2, 1);
      nxt();
      wb(11);
      smp(); chk("R9 dropped insert", iss_valid, 0);
      nxt();
      smp(); chk("R9 oldest kept", iss_op, 50);
      nxt();
      smp(); chk("R9 boundary kept", iss_op, 51);
      nxt();
      smp(); chk("R9 younger gone", iss_valid, 0);
      nxt();
    end

    // R10 last slot insert with dispatch
    for (int k = 0; k < 6; k++) begin
      ins(60 + k, k, 12, 0, 2, 1);
      nxt();
    end
    ins(66, 6, 13, 0, 2, 1);
    nxt();
    wb(13);
    nxt();
    smp(); chk("R10 dispatch", iss_op, 66); chk("R10 not full", full, 0);
    ins(67, 7, 12, 0, 2, 1);
    nxt();
    smp(); chk("R10 seven", full, 0);
    ins(68, 8, 12, 0, 2, 1);
    nxt();
    smp(); chk("R10 full", full, 1); wb(12);
    nxt();
    for (int k = 0; k < 8; k++) begin
      smp();
      chk("R10 valid", iss_valid, 1);
      chk("R10 order", iss_op, (k < 6) ? 60 + k : 61 + k);
      nxt();
    end
    smp(); chk("R10 drained", iss_valid, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule